// File: doc/BRIEF.md
# DMA Interrupt Vector Controller

This block gathers interrupt events from a DMA engine and hands a vector back to the processor when it runs an interrupt-acknowledge read. It has four kinds of source: sixteen task events, eight execution-unit events, one debug event and one transfer-error event. Each event sets a sticky pending flag. Software clears a flag by writing 1 to it. A mask register blocks a source from both the interrupt line and the vector decode.

There are two vectors, and each has its own fixed-priority chain. Vector 1 covers the tasks, and task 15 has the highest priority. Vector 2 covers the debug source, the transfer error and the execution units, in that order of priority, with execution unit 0 lowest. Software sets the upper nibble of each vector. The hardware fills in the lower nibble from the winning source, or with 1111 when no unmasked source in that chain is pending. An acknowledge strobe returns vector 1 if any unmasked task is pending, and vector 2 otherwise.

A transfer error records the number of the task that took it. Unless the error-ignore control bit is set, it also halts that task. A two-state machine drives the halt output. In ST_RUN the halt output is low. The transition RUN_TO_HALT is taken on a transfer error while error-ignore is clear. In ST_HALT the halt output is high and the halt task number is shown. The transition HALT_TO_RUN is taken when software clears the error pending flag and no new error arrives in the same cycle. A new error that arrives while in ST_HALT keeps the machine there and updates the task number.

Top module: `dma_irq_vector_ctrl`

## Requirements
- R1: After reset the pending word reads 0 and the control word reads 0. The mask word reads 0xA0FF_FFFF, which means every source is masked. The vector word reads 0x0F0F. irq, halt_req and ack_valid are low.
- R2: An event pulse sets its pending flag on the next clock edge. Writing 1 to a flag at address 0 clears it, and writing 0 leaves it unchanged. When a set and a clear hit the same flag in the same cycle, the flag ends up set.
- R3: A mask bit of 1 removes its source from the decode and from irq. irq is high exactly when some unmasked flag is pending.
- R4: The lower nibble of vector 1 is the number of the highest unmasked pending task, with task 15 highest.
- R5: The lower nibble of vector 2 is decoded from the winning source. The codes are 9 for debug, 8 for transfer error and n for execution unit n. Priority runs debug, then error, then unit 7 down to unit 0.
- R6: A lower nibble reads 1111 when no unmasked source in its chain is pending.
- R7: An iack pulse in one cycle gives ack_valid high for one cycle, after the next edge. ack_vector carries vector 1 if an unmasked task was pending and vector 2 otherwise.
- R8: A transfer error sets pending bit 29 and stores err_task in pending bits 28:25. The stored number is kept after bit 29 is cleared.
- R9: With control bit 8 clear, a transfer error raises halt_req after the next edge, and halt_task shows the offending task. halt_req stays high until bit 29 is cleared.
- R10: With control bit 8 set, a transfer error leaves halt_req low but is still recorded. It still raises irq when its mask bit is clear.
- R11: The register map is as follows. Address 0 holds pending: debug at bit 31, error at bit 29, error task at bits 28:25, units at bits 23:16 and tasks at bits 15:0. Address 1 holds the mask, with the same bit positions. Address 2 holds control: the vector 1 upper nibble at bits 3:0, the vector 2 upper nibble at bits 7:4 and error-ignore at bit 8. Address 3 holds vector 1 at bits 15:8 and vector 2 at bits 7:0, and is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| task_ev | input | 16 | Task interrupt event pulses |
| eu_ev | input | 8 | Execution-unit event pulses |
| dbg_ev | input | 1 | Debug event pulse |
| err_ev | input | 1 | Transfer-error event pulse |
| err_task | input | 4 | Task number that took the error |
| iack | input | 1 | Interrupt-acknowledge strobe |
| ack_valid | output | 1 | Acknowledge response valid |
| ack_vector | output | 8 | Vector returned by the acknowledge |
| irq | output | 1 | Interrupt request |
| halt_req | output | 1 | Halt request to the task engine |
| halt_task | output | 4 | Task number to halt |

## Verification
Every pair of tasks is raised together with a moving execution-unit event. This checks that the higher-numbered task wins and that tasks take precedence over units in the acknowledge. Every pair of the ten second-chain sources is swept the same way, which checks the debug-over-error-over-unit order. A sweep that leaves exactly one source unmasked among many pending sources tells correct mask gating apart from plain priority. The all-masked case produces the 1111 nibble. Error events with and without the ignore bit, and a set that coincides with a clear, separate halting from mere recording.

// File: rtl/dvc_pkg.sv
package dvc_pkg;
    localparam int NUM_TASK    = 16;
    localparam int NUM_EU      = 8;
    localparam int CODE_W      = 4;
    localparam int REG_W       = 32;
    localparam int POS_DBG     = 31;
    localparam int POS_ERR     = 29;
    localparam int POS_ENUM_LO = 25;
    localparam int POS_EU_LO   = 16;
    localparam int POS_TASK_LO = 0;
    localparam int POS_IGNORE  = 8;

    typedef enum logic [1:0] {
        A_PEND = 2'd0,
        A_MASK = 2'd1,
        A_CTRL = 2'd2,
        A_VEC  = 2'd3
    } reg_addr_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } halt_state_e;
endpackage

// File: rtl/dvc_pend_bank.sv
module dvc_pend_bank #(
    parameter int NT = 16,
    parameter int NE = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] task_set,
    input  logic [NE-1:0] eu_set,
    input  logic          dbg_set,
    input  logic          err_set,
    input  logic [CW-1:0] err_who,
    input  logic [NT-1:0] task_clr,
    input  logic [NE-1:0] eu_clr,
    input  logic          dbg_clr,
    input  logic          err_clr,
    output logic [NT-1:0] task_q,
    output logic [NE-1:0] eu_q,
    output logic          dbg_q,
    output logic          err_q,
    output logic [CW-1:0] err_num
);
    // A set in the same cycle as a clear wins: the OR comes after the AND.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            task_q  <= '0;
            eu_q    <= '0;
            dbg_q   <= 1'b0;
            err_q   <= 1'b0;
            err_num <= '0;
        end else begin
            task_q <= (task_q & ~task_clr) | task_set;
            eu_q   <= (eu_q & ~eu_clr) | eu_set;
            dbg_q  <= (dbg_q & ~dbg_clr) | dbg_set;
            err_q  <= (err_q & ~err_clr) | err_set;
            if (err_set) begin
                err_num <= err_who;
            end
        end
    end
endmodule

// File: rtl/dvc_prio_enc.sv
module dvc_prio_enc #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] code
);
    // Ascending scan: the last set bit found, i.e. the highest index, wins.
    always_comb begin
        hit  = 1'b0;
        code = '1;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                hit  = 1'b1;
                code = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dma_irq_vector_ctrl.sv
module dma_irq_vector_ctrl
    import dvc_pkg::*;
#(
    parameter int NT = NUM_TASK,
    parameter int NE = NUM_EU,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [1:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    input  logic [NT-1:0] task_ev,
    input  logic [NE-1:0] eu_ev,
    input  logic          dbg_ev,
    input  logic          err_ev,
    input  logic [CW-1:0] err_task,
    input  logic          iack,
    output logic          ack_valid,
    output logic [7:0]    ack_vector,
    output logic          irq,
    output logic          halt_req,
    output logic [CW-1:0] halt_task
);
    localparam int C2N = NE + 2;
    localparam int VW  = 2 * CW;
    localparam logic [REG_W-1:0] MASK_BITS =
        (REG_W'(1) << POS_DBG) | (REG_W'(1) << POS_ERR) |
        (REG_W'((64'd1 << NE) - 1) << POS_EU_LO) |
        (REG_W'((64'd1 << NT) - 1) << POS_TASK_LO);

    logic wr_pend, wr_mask, wr_ctrl;
    assign wr_pend = bus_we && (bus_addr == A_PEND);
    assign wr_mask = bus_we && (bus_addr == A_MASK);
    assign wr_ctrl = bus_we && (bus_addr == A_CTRL);

    // Mask and control registers
    logic [REG_W-1:0] mask_q;
    logic [CW-1:0]    v1_hi, v2_hi;
    logic             err_ignore_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q       <= MASK_BITS;
            v1_hi        <= '0;
            v2_hi        <= '0;
            err_ignore_q <= 1'b0;
        end else begin
            if (wr_mask) begin
                mask_q <= bus_wdata & MASK_BITS;
            end
            if (wr_ctrl) begin
                v1_hi        <= bus_wdata[CW-1:0];
                v2_hi        <= bus_wdata[2*CW-1:CW];
                err_ignore_q <= bus_wdata[POS_IGNORE];
            end
        end
    end

    // Pending flags
    logic [NT-1:0] task_q;
    logic [NE-1:0] eu_q;
    logic          dbg_q, err_q;
    logic [CW-1:0] err_num;
    logic          err_clr;

    assign err_clr = wr_pend & bus_wdata[POS_ERR];

    dvc_pend_bank #(.NT(NT), .NE(NE), .CW(CW)) pend_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .task_set (task_ev),
        .eu_set   (eu_ev),
        .dbg_set  (dbg_ev),
        .err_set  (err_ev),
        .err_who  (err_task),
        .task_clr (wr_pend ? bus_wdata[POS_TASK_LO +: NT] : '0),
        .eu_clr   (wr_pend ? bus_wdata[POS_EU_LO +: NE] : '0),
        .dbg_clr  (wr_pend & bus_wdata[POS_DBG]),
        .err_clr  (err_clr),
        .task_q   (task_q),
        .eu_q     (eu_q),
        .dbg_q    (dbg_q),
        .err_q    (err_q),
        .err_num  (err_num)
    );

    // Two priority chains
    logic [NT-1:0]  task_live;
    logic [C2N-1:0] c2_live;
    logic           hit1, hit2;
    logic [CW-1:0]  code1, code2;
    logic [VW-1:0]  vec1, vec2;

    assign task_live = task_q & ~mask_q[POS_TASK_LO +: NT];
    assign c2_live   = {dbg_q & ~mask_q[POS_DBG],
                        err_q & ~mask_q[POS_ERR],
                        eu_q & ~mask_q[POS_EU_LO +: NE]};

    dvc_prio_enc #(.N(NT), .IW(CW)) enc_task_i (
        .req (task_live), .hit (hit1), .code (code1)
    );
    dvc_prio_enc #(.N(C2N), .IW(CW)) enc_unit_i (
        .req (c2_live), .hit (hit2), .code (code2)
    );

    assign vec1 = {v1_hi, code1};
    assign vec2 = {v2_hi, code2};
    assign irq  = hit1 | hit2;

    // Acknowledge response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_valid  <= 1'b0;
            ack_vector <= '0;
        end else begin
            ack_valid <= iack;
            if (iack) begin
                ack_vector <= hit1 ? vec1 : vec2;
            end
        end
    end

    // Register read mux
    logic [REG_W-1:0] pend_word;
    always_comb begin
        pend_word                       = '0;
        pend_word[POS_DBG]              = dbg_q;
        pend_word[POS_ERR]              = err_q;
        pend_word[POS_ENUM_LO +: CW]    = err_num;
        pend_word[POS_EU_LO +: NE]      = eu_q;
        pend_word[POS_TASK_LO +: NT]    = task_q;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_PEND: bus_rdata = pend_word;
            A_MASK: bus_rdata = mask_q;
            A_CTRL: begin
                bus_rdata[CW-1:0]       = v1_hi;
                bus_rdata[2*CW-1:CW]    = v2_hi;
                bus_rdata[POS_IGNORE]   = err_ignore_q;
            end
            default: bus_rdata[2*VW-1:0] = {vec1, vec2};
        endcase
    end

    // Halt state machine
    halt_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        halt_req  = 1'b0;
        halt_task = err_num;
        unique case (state_q)
            ST_RUN: begin
                if (err_ev && !err_ignore_q) begin
                    state_d = ST_HALT;          // RUN_TO_HALT
                end
            end
            ST_HALT: begin
                halt_req = 1'b1;
                if (err_clr && !err_ev) begin
                    state_d = ST_RUN;           // HALT_TO_RUN
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    logic wdata_unused;
    assign wdata_unused = ^{bus_wdata[REG_W-1:POS_IGNORE+1], bus_wdata[POS_ENUM_LO +: CW], bus_wdata[POS_DBG-1]};
endmodule

// File: rtl/dvc_checker.sv
module dvc_checker #(
    parameter int NT = 16,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NT-1:0] task_ev,
    input logic          err_ev,
    input logic [CW-1:0] err_task,
    input logic          iack,
    input logic          ack_valid,
    input logic          irq,
    input logic          halt_req,
    input logic [CW-1:0] halt_task,
    input logic          err_ignore,
    input logic [NT-1:0] task_pend,
    input logic [NT-1:0] task_mask,
    input logic          err_pend,
    input logic [CW-1:0] err_num
);
    p_task_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|task_ev) |=> ((task_pend & $past(task_ev)) == $past(task_ev)));

    p_irq_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((task_pend & ~task_mask) != '0) |-> irq);

    p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iack |=> ack_valid);

    p_ack_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !iack |=> !ack_valid);

    p_err_record_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_ev |=> (err_pend && err_num == $past(err_task)));

    p_halt_on_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ev && !err_ignore) |=> (halt_req && halt_task == $past(err_task)));

    p_no_halt_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ev && err_ignore && !halt_req) |=> !halt_req);
endmodule

bind dma_irq_vector_ctrl dvc_checker #(.NT(NT), .CW(CW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .task_ev    (task_ev),
    .err_ev     (err_ev),
    .err_task   (err_task),
    .iack       (iack),
    .ack_valid  (ack_valid),
    .irq        (irq),
    .halt_req   (halt_req),
    .halt_task  (halt_task),
    .err_ignore (err_ignore_q),
    .task_pend  (task_q),
    .task_mask  (mask_q[NT-1:0]),
    .err_pend   (err_q),
    .err_num    (err_num)
);

// File: tb/dma_irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_irq_vector_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] task_ev = '0;
    logic [7:0]  eu_ev = '0;
    logic        dbg_ev = 1'b0;
    logic        err_ev = 1'b0;
    logic [3:0]  err_task = '0;
    logic        iack = 1'b0;
    logic        ack_valid;
    logic [7:0]  ack_vector;
    logic        irq;
    logic        halt_req;
    logic [3:0]  halt_task;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dma_irq_vector_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .task_ev(task_ev),
        .eu_ev(eu_ev), .dbg_ev(dbg_ev), .err_ev(err_ev), .err_task(err_task),
        .iack(iack), .ack_valid(ack_valid), .ack_vector(ack_vector),
        .irq(irq), .halt_req(halt_req), .halt_task(halt_task)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int top_bit(input logic [31:0] v, input int n);
        int r = 15;
        for (int i = 0; i < n; i++) if (v[i]) r = i;
        return r;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [15:0] t, input logic [7:0] e, input logic d,
                         input logic er, input logic [3:0] et);
        @(negedge clk);
        task_ev = t; eu_ev = e; dbg_ev = d; err_ev = er; err_task = et;
        @(negedge clk);
        task_ev = '0; eu_ev = '0; dbg_ev = 1'b0; err_ev = 1'b0;
    endtask

    task automatic do_ack(input string req, input logic [7:0] exp);
        @(negedge clk);
        iack = 1'b1;
        @(negedge clk);
        iack = 1'b0;
        chk({req, " ack_valid"}, {31'd0, ack_valid}, 32'd1);
        chk({req, " ack_vector"}, {24'd0, ack_vector}, {24'd0, exp});
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, d); chk("R1 pending", d, 32'h0);
        rd(2'd1, d); chk("R1 mask", d, 32'hA0FF_FFFF);
        rd(2'd2, d); chk("R1 ctrl", d, 32'h0);
        rd(2'd3, d); chk("R1 vectors", d, 32'h0000_0F0F);
        chk("R1 irq/halt/ack", {29'd0, irq, halt_req, ack_valid}, 32'd0);

        // R11 control layout: v1 hi=3, v2 hi=C, ignore=1
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h1C3);
        rd(2'd2, d); chk("R11 ctrl readback", d, 32'h1C3);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, d); chk("R11 vector read-only", d, 32'h0000_3FCF);

        // R4 / R7: every task pair plus one unit event
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                logic [15:0] tv;
                tv = 16'(1 << i) | 16'(1 << j);
                wr(2'd0, 32'hFFFF_FFFF);
                pulse(tv, 8'(1 << (j % 8)), 1'b0, 1'b0, 4'd0);
                rd(2'd3, d);
                chk("R4 vec1 task priority", {16'd0, d[15:8]}, {24'd0, 4'h3, 4'(top_bit({16'd0, tv}, 16))});
                chk("R5 vec2 unit code", {16'd0, d[7:0]}, {24'd0, 4'hC, 4'(j % 8)});
                chk("R3 irq with pending", {31'd0, irq}, 32'd1);
                do_ack("R7 task precedence", {4'h3, 4'(top_bit({16'd0, tv}, 16))});
            end
        end

        // R5 / R7: second chain pairs (0..7 units, 8 error, 9 debug)
        for (int i = 0; i < 10; i++) begin
            for (int j = 0; j < 10; j++) begin
                logic [9:0] sv;
                sv = 10'(1 << i) | 10'(1 << j);
                wr(2'd0, 32'hFFFF_FFFF);
                pulse(16'd0, sv[7:0], sv[9], sv[8], 4'd2);
                rd(2'd3, d);
                chk("R5 vec2 chain priority", {24'd0, d[7:0]}, {24'd0, 4'hC, 4'(top_bit({22'd0, sv}, 10))});
                chk("R6 vec1 empty chain", {24'd0, d[15:8]}, 32'h3F);
                do_ack("R7 vector 2 selected", {4'hC, 4'(top_bit({22'd0, sv}, 10))});
            end
        end
        chk("R10 no halt with ignore", {31'd0, halt_req}, 32'd0);

        // R3 / R6: all sources pending, one unmasked at a time
        wr(2'd0, 32'hFFFF_FFFF);
        pulse(16'hFFFF, 8'hFF, 1'b1, 1'b1, 4'd2);
        for (int k = 0; k < 16; k++) begin
            wr(2'd1, 32'hA0FF_FFFF & ~(32'd1 << k));
            rd(2'd3, d);
            chk("R3 single unmasked task", d, {16'd0, 4'h3, 4'(k), 8'hCF});
        end
        for (int k = 0; k < 10; k++) begin
            int pos;
            pos = (k == 9) ? 31 : (k == 8) ? 29 : 16 + k;
            wr(2'd1, 32'hA0FF_FFFF & ~(32'd1 << pos));
            rd(2'd3, d);
            chk("R3 single unmasked chain-2 source", d, {16'd0, 8'h3F, 4'hC, 4'(k)});
        end
        wr(2'd1, 32'hA0FF_FFFF);
        rd(2'd3, d); chk("R6 all masked vectors", d, 32'h0000_3FCF);
        chk("R3 irq low when all masked", {31'd0, irq}, 32'd0);
        do_ack("R6 all masked ack", 8'hCF);

        // R2 set wins over clear, W1C, write 0 keeps
        wr(2'd1, 32'h0);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); chk("R2 W1C clears all flags", d & 32'hA0FF_FFFF, 32'h0);
        @(negedge clk);
        task_ev = 16'h0020; bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h20;
        @(negedge clk);
        task_ev = '0; bus_we = 1'b0;
        rd(2'd0, d); chk("R2 set wins", {31'd0, d[5]}, 32'd1);
        wr(2'd0, 32'h0);
        rd(2'd0, d); chk("R2 write zero keeps", {31'd0, d[5]}, 32'd1);
        wr(2'd0, 32'h20);
        rd(2'd0, d); chk("R2 W1C clears", {31'd0, d[5]}, 32'd0);

        // R8 / R9: error with ignore clear
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd2, 32'h0C3);
        pulse(16'd0, 8'd0, 1'b0, 1'b1, 4'hB);
        chk("R9 halt raised", {27'd0, halt_req, halt_task}, {27'd0, 1'b1, 4'hB});
        rd(2'd0, d); chk("R8 error recorded", d, 32'h2000_0000 | (32'hB << 25));
        chk("R3 irq from error", {31'd0, irq}, 32'd1);
        wr(2'd0, 32'h0);
        chk("R9 halt held", {31'd0, halt_req}, 32'd1);
        wr(2'd0, 32'h2000_0000);
        chk("R9 halt released", {31'd0, halt_req}, 32'd0);
        rd(2'd0, d); chk("R8 number kept", d, 32'hB << 25);

        // R10: error with ignore set
        wr(2'd2, 32'h1C3);
        pulse(16'd0, 8'd0, 1'b0, 1'b1, 4'h6);
        chk("R10 no halt", {31'd0, halt_req}, 32'd0);
        rd(2'd0, d); chk("R10 still recorded", d, 32'h2000_0000 | (32'h6 << 25));
        chk("R10 irq raised", {31'd0, irq}, 32'd1);
        wr(2'd1, 32'h2000_0000);
        chk("R10 masked error no irq", {31'd0, irq}, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule